// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns a stream of stereo sample pairs into a three-wire serial audio signal: a bit clock, a word-select (channel) line and a serial data line. Sample pairs come from an external show-ahead FIFO. The FIFO presents the pair at its output while it is non-empty, and the block takes the pair with a one-cycle pop strobe. The right sample is in the low half of the FIFO word and the left sample is in the high half. Samples are 16 bits wide and are sent MSB first.

The bit clock is the system clock divided by an even ratio. Each channel slot is 16 plus a programmable extension bit clocks long. The block supports three framings: I2S (data starts one bit clock after the word-select edge), left-justified and right-justified. It also has a bit-clock inversion control, a word-select polarity control, and a channel mode (stereo, mute, mono-left, mono-right). The channel mode is only taken up at pair boundaries.

Raising the enable starts a frame with a dummy left slot. Lowering the enable lets the block drain the FIFO. Once the FIFO is empty, the block parks its pins at idle levels.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset and whenever idle (busy = 0), bclk_o = 0, sdo_o = 0, fifo_pop = 0, and ws_o equals ws_left_high.
- R2: While busy, each bit period is 2*(bclk_half+1) system clocks. The internal bit clock is low for the first half and high for the second half. ws_o and sdo_o change only at the end of a bit period. bclk_o equals the internal bit clock when bclk_invert = 0 and its complement when bclk_invert = 1, so data is stable at the bclk_o rising edge for invert 0 and at the falling edge for invert 1.
- R3: Every slot lasts 16 + slot_ext bit periods. Slots alternate left, right, left and so on, starting with left. ws_o = 0 in left slots and 1 in right slots when ws_left_high = 0, and the reverse when it is 1.
- R4: The first left slot after start carries only zeros. At the end of each left slot the FIFO is popped if it is non-empty. The next right slot sends fifo_rdata[15:0] and the left slot after that sends fifo_rdata[31:16].
- R5: Within a slot of bit index j (0-based), the sample is placed as follows. With fmt_sel = 0 (I2S), sample bit 15 is at j = 1. With fmt_sel = 1 or 3 (left-justified), bit 15 is at j = 0. With fmt_sel = 2 (right-justified), bit 0 is at the last index. All other positions send 0. In I2S mode with slot_ext = 0, the LSB does not fit and is dropped.
- R6: With chan_mode = 1 (mute), sdo_o stays 0. Clocks, word-select and FIFO pops run exactly as in stereo (chan_mode = 0).
- R7: With chan_mode = 2 (mono-left), right slots send 0. With chan_mode = 3 (mono-right), left slots send 0. FIFO pops are unchanged.
- R8: chan_mode is sampled only at start and at the end of each left slot. A change made in the middle of a right-then-left pair takes effect with the next pair.
- R9: If tx_enable is low and the FIFO is empty at the end of a left slot, busy falls on the next clock and the pins take their R1 levels. Before that point the block keeps transmitting, even with tx_enable low.
- R10: If the FIFO is empty at the end of a left slot while tx_enable is high, no pop is issued and the following pair of slots sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Start request; low requests stop after drain |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| slot_ext | input | 5 | Extra bit clocks per slot beyond 16 |
| bclk_half | input | 8 | Bit clock half period minus one, in system clocks |
| ws_left_high | input | 1 | Word-select level of the left channel |
| bclk_invert | input | 1 | Invert the bit clock while running |
| chan_mode | input | 2 | 0 stereo, 1 mute, 2 mono-left, 3 mono-right |
| fifo_empty | input | 1 | FIFO holds no pair |
| fifo_rdata | input | 32 | FIFO head: left in [31:16], right in [15:0] |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| busy | output | 1 | Transmitter running |
| ws_o | output | 1 | Word-select line |
| bclk_o | output | 1 | Bit clock line |
| sdo_o | output | 1 | Serial data line |

## Verification
The hardest situation to reach is a channel-mode change that lands in the middle of a pair. It must not alter the pair already in flight, and it must take hold on the very next pair. The stimulus waits for busy and counts out one dummy slot plus two bit periods, which places the change inside the first right slot. It then expects the first pair in the old mode and every later pair in the new mode. The underrun case is similar. The bench holds tx_enable high past the last pair's left-slot end by a counted number of cycles, so that one zero pair must appear before the stop.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_SPARE = 2'd3
  } frame_fmt_e;

  typedef enum logic [1:0] {
    CH_STEREO = 2'd0,
    CH_MUTE   = 2'd1,
    CH_MONO_L = 2'd2,
    CH_MONO_R = 2'd3
  } ch_mode_e;

  localparam logic CHAN_L = 1'b0;
  localparam logic CHAN_R = 1'b1;

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             phase_q, phase_n;
  logic             half_done;

  assign half_done = (cnt_q == div);

  always_comb begin
    cnt_n   = cnt_q;
    phase_n = phase_q;
    if (!run) begin
      cnt_n   = '0;
      phase_n = 1'b0;
    end else if (half_done) begin
      cnt_n   = '0;
      phase_n = ~phase_q;
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
    end
  end

  assign phase   = phase_q;
  assign bit_end = run & phase_q & half_done;

  // R2: the bit clock level holds until its half-period count completes
  a_r2_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && ($past(cnt_q) != $past(div))) |-> $stable(phase_q));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FIELD_W  = 5,
  parameter int IDX_W    = 6,
  parameter int WORD_W   = 2 * SAMPLE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_enable,
  input  logic               bit_end,
  input  logic [FIELD_W-1:0] slot_ext,
  input  logic [1:0]         chan_mode,
  input  logic               fifo_empty,
  input  logic [WORD_W-1:0]  fifo_rdata,
  output logic               fifo_pop,
  output logic               running,
  output logic               chan,
  output logic [IDX_W-1:0]   idx,
  output logic [WORD_W-1:0]  pair,
  output logic [1:0]         mode
);

  logic              running_q, running_n;
  logic              chan_q, chan_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [WORD_W-1:0] pair_q, pair_n;
  logic [1:0]        mode_q, mode_n;
  logic [IDX_W-1:0]  slot_last;
  logic              at_last, left_end, stop_now, upd;

  assign slot_last = IDX_W'(SAMPLE_W) + IDX_W'(slot_ext) - IDX_W'(1);
  assign at_last   = (idx_q == slot_last);
  assign left_end  = running_q & bit_end & at_last & (chan_q == CHAN_L);
  assign stop_now  = left_end & ~tx_enable & fifo_empty;
  assign upd       = ~running_q | bit_end;

  always_comb begin
    running_n = running_q;
    chan_n    = chan_q;
    idx_n     = idx_q;
    pair_n    = pair_q;
    mode_n    = mode_q;
    if (!running_q) begin
      if (tx_enable) begin
        running_n = 1'b1;
        chan_n    = CHAN_L;
        idx_n     = '0;
        pair_n    = '0;
        mode_n    = chan_mode;
      end
    end else if (bit_end) begin
      if (at_last) begin
        idx_n = '0;
        if (chan_q == CHAN_L) begin
          if (stop_now) begin
            running_n = 1'b0;
          end else begin
            chan_n = CHAN_R;
            pair_n = fifo_empty ? '0 : fifo_rdata;
            mode_n = chan_mode;
          end
        end else begin
          chan_n = CHAN_L;
        end
      end else begin
        idx_n = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      chan_q    <= CHAN_L;
      idx_q     <= '0;
      pair_q    <= '0;
      mode_q    <= 2'd0;
    end else if (upd) begin
      running_q <= running_n;
      chan_q    <= chan_n;
      idx_q     <= idx_n;
      pair_q    <= pair_n;
      mode_q    <= mode_n;
    end
  end

  assign fifo_pop = left_end & ~fifo_empty;
  assign running  = running_q;
  assign chan     = chan_q;
  assign idx      = idx_q;
  assign pair     = pair_q;
  assign mode     = mode_q;

  // R8: channel mode is only re-sampled at a left-slot end
  a_r8_mode_only_at_pair_end: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && !$past(left_end)) |-> $stable(mode_q));

  // R3: slot position advances only when a bit period ends
  a_r3_slot_moves_on_bit_end: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && !$past(bit_end)) |-> ($stable(chan_q) && $stable(idx_q)));

endmodule

// File: rtl/sertx_bitsel.sv
module sertx_bitsel
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FIELD_W  = 5,
  parameter int IDX_W    = 6,
  parameter int WORD_W   = 2 * SAMPLE_W
) (
  input  logic [WORD_W-1:0]  pair,
  input  logic               chan,
  input  logic [IDX_W-1:0]   idx,
  input  logic [1:0]         fmt_sel,
  input  logic [FIELD_W-1:0] slot_ext,
  input  logic [1:0]         mode,
  output logic               data_bit
);

  logic [IDX_W-1:0]    lead;
  logic [IDX_W-1:0]    rel;
  logic [IDX_W-1:0]    pos;
  logic                in_window;
  logic                silenced;
  logic [SAMPLE_W-1:0] sample;
  logic [SAMPLE_W-1:0] hits;

  always_comb begin
    case (frame_fmt_e'(fmt_sel))
      FMT_I2S:   lead = IDX_W'(1);
      FMT_RIGHT: lead = IDX_W'(slot_ext);
      default:   lead = '0;
    endcase
  end

  assign rel       = idx - lead;
  assign in_window = (idx >= lead) && (rel < IDX_W'(SAMPLE_W));
  assign pos       = IDX_W'(SAMPLE_W - 1) - rel;
  assign sample    = (chan == CHAN_R) ? pair[SAMPLE_W-1:0] : pair[WORD_W-1:SAMPLE_W];

  genvar b;
  generate
    for (b = 0; b < SAMPLE_W; b++) begin : g_pick
      assign hits[b] = (pos == IDX_W'(b)) & sample[b];
    end
  endgenerate

  always_comb begin
    case (ch_mode_e'(mode))
      CH_MUTE:   silenced = 1'b1;
      CH_MONO_L: silenced = (chan == CHAN_R);
      CH_MONO_R: silenced = (chan == CHAN_L);
      default:   silenced = 1'b0;
    endcase
  end

  assign data_bit = in_window & ~silenced & (|hits);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FIELD_W  = 5,
  parameter int DIV_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_enable,
  input  logic [1:0]            fmt_sel,
  input  logic [FIELD_W-1:0]    slot_ext,
  input  logic [DIV_W-1:0]      bclk_half,
  input  logic                  ws_left_high,
  input  logic                  bclk_invert,
  input  logic [1:0]            chan_mode,
  input  logic                  fifo_empty,
  input  logic [2*SAMPLE_W-1:0] fifo_rdata,
  output logic                  fifo_pop,
  output logic                  busy,
  output logic                  ws_o,
  output logic                  bclk_o,
  output logic                  sdo_o
);

  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int IDX_W  = $clog2(SAMPLE_W + (1 << FIELD_W));

  logic              running;
  logic              phase;
  logic              bit_end;
  logic              chan;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] pair;
  logic [1:0]        mode;
  logic              data_bit;

  sertx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .div     (bclk_half),
    .phase   (phase),
    .bit_end (bit_end)
  );

  sertx_framer #(
    .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .bit_end    (bit_end),
    .slot_ext   (slot_ext),
    .chan_mode  (chan_mode),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_pop   (fifo_pop),
    .running    (running),
    .chan       (chan),
    .idx        (idx),
    .pair       (pair),
    .mode       (mode)
  );

  sertx_bitsel #(
    .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_bitsel (
    .pair     (pair),
    .chan     (chan),
    .idx      (idx),
    .fmt_sel  (fmt_sel),
    .slot_ext (slot_ext),
    .mode     (mode),
    .data_bit (data_bit)
  );

  assign busy   = running;
  assign bclk_o = running & (phase ^ bclk_invert);
  assign ws_o   = running ? (chan ^ ws_left_high) : ws_left_high;
  assign sdo_o  = running & data_bit;

  // R1: idle pin levels
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bclk_o && !sdo_o && !fifo_pop && (ws_o == ws_left_high)));

  // R10: a pop is never issued against an empty FIFO
  a_r10_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R6: a pair latched in mute mode never drives the data line
  a_r6_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode == CH_MUTE)) |-> !sdo_o);

  // R5: in I2S framing the first bit of each slot is the delay bit
  a_r5_i2s_delay_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (fmt_sel == FMT_I2S) && (idx == '0)) |-> !sdo_o);

endmodule

// File: tb/tb_audio_serial_tx.sv
module tb_audio_serial_tx;

  logic        clk;
  logic        rst_n;
  logic        tx_enable;
  logic [1:0]  fmt_sel;
  logic [4:0]  slot_ext;
  logic [7:0]  bclk_half;
  logic        ws_left_high;
  logic        bclk_invert;
  logic [1:0]  chan_mode;
  logic        fifo_empty;
  logic [31:0] fifo_rdata;
  logic        fifo_pop;
  logic        busy;
  logic        ws_o;
  logic        bclk_o;
  logic        sdo_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [31:0] mem [0:255];
  logic [7:0]  rd;
  logic [7:0]  wr;
  logic [31:0] exp_w [0:15];

  logic cap_on;
  logic prev_b;
  logic cap_ws [0:511];
  logic cap_sd [0:511];
  int   cap_t  [0:511];
  int   cap_n;

  audio_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .fmt_sel(fmt_sel),
    .slot_ext(slot_ext), .bclk_half(bclk_half), .ws_left_high(ws_left_high),
    .bclk_invert(bclk_invert), .chan_mode(chan_mode), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .busy(busy), .ws_o(ws_o),
    .bclk_o(bclk_o), .sdo_o(sdo_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign fifo_empty = (rd == wr);
  assign fifo_rdata = mem[rd];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd <= 8'd0;
    else if (fifo_pop) rd <= rd + 8'd1;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!cap_on) begin
      cap_n  = 0;
      prev_b = 1'b0;
    end else begin
      if (busy && (bclk_invert ? (prev_b && !bclk_o) : (!prev_b && bclk_o)) && cap_n < 512) begin
        cap_ws[cap_n] = ws_o;
        cap_sd[cap_n] = sdo_o;
        cap_t[cap_n]  = cyc;
        cap_n++;
      end
      prev_b = bclk_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int fmt, input int n, input int j, input logic [15:0] w);
    int off;
    off = (fmt == 0) ? 1 : (fmt == 2) ? (n - 16) : 0;
    if (j >= off && (j - off) < 16) return w[15 - (j - off)];
    return 1'b0;
  endfunction

  task automatic test_reset();
    // R1: idle pins after reset, for both word-select polarities
    ws_left_high = 1'b1;
    @(negedge clk);
    check(!busy && !bclk_o && !sdo_o && !fifo_pop, "R1", "idle busy/bclk/sdo/pop", {busy, bclk_o, sdo_o, fifo_pop}, 0);
    check(ws_o == 1'b1, "R1", "idle ws with left-high", ws_o, 1);
    ws_left_high = 1'b0;
    @(negedge clk);
    check(ws_o == 1'b0, "R1", "idle ws with left-low", ws_o, 0);
  endtask

  task automatic run_case(input string req, input int fmt, input int ext, input int div,
                          input bit wsp, input bit bcp, input int ma, input int mb,
                          input int nw, input int under);
    int n, p, base, slots, bad_ws, bad_sd, bad_per, first_k, s, j, pr, m, act_sd, act_ws, guard;
    logic [31:0] wd;
    logic [15:0] half;
    bit ch, eb;
    n = 16 + ext;
    p = 2 * (div + 1);
    @(negedge clk);
    fmt_sel      = 2'(fmt);
    slot_ext     = 5'(ext);
    bclk_half    = 8'(div);
    ws_left_high = wsp;
    bclk_invert  = bcp;
    chan_mode    = 2'(ma);
    base = int'(rd);
    for (int i = 0; i < nw; i++) begin
      wd = 32'h9E37_79B9 * (i + 3) ^ (32'h1357_2468 << (i % 7)) ^ (32'(fmt) << 9) ^ (32'(ma) << 21);
      exp_w[i] = wd;
      mem[wr]  = wd;
      wr       = wr + 8'd1;
    end
    cap_on = 1'b1;
    @(negedge clk);
    tx_enable = 1'b1;
    guard = 0;
    while (!busy && guard < 100) begin @(negedge clk); guard++; end
    if (under == 0) tx_enable = 1'b0;
    // place a mode change inside the first right slot (R8)
    repeat (n * p + 2 * p) @(negedge clk);
    chan_mode = 2'(mb);
    if (under != 0) begin
      repeat ((1 + 2 * nw) * n * p + 5 - (n * p + 2 * p)) @(negedge clk);
      tx_enable = 1'b0;
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    slots = 1 + 2 * (nw + under);
    // R9: stream length shows drain before stop; R3: slot length
    check(cap_n == slots * n, "R9", "captured bit count", cap_n, slots * n);
    bad_ws = 0; bad_sd = 0; bad_per = 0; first_k = -1; act_sd = 0; act_ws = 0;
    for (int k = 0; k < cap_n && k < slots * n; k++) begin
      s  = k / n;
      j  = k % n;
      ch = (s % 2) == 1;
      pr = (s + 1) / 2;
      wd = (s == 0 || pr > nw) ? 32'h0 : exp_w[pr - 1];
      half = ch ? wd[15:0] : wd[31:16];
      m  = (pr <= 1) ? ma : mb;
      eb = exp_bit(fmt, n, j, half);
      if (m == 1 || (m == 2 && ch) || (m == 3 && !ch)) eb = 1'b0;
      if (cap_ws[k] != (ch ^ wsp)) begin
        bad_ws++;
        if (act_ws == 0) act_ws = k + 1;
      end
      if (cap_sd[k] != eb) begin
        bad_sd++;
        if (first_k < 0) begin first_k = k; act_sd = cap_sd[k]; end
      end
      if (k > 0 && (cap_t[k] - cap_t[k-1]) != p) bad_per++;
    end
    check(bad_ws == 0, "R3", "word-select mismatches (first at bit+1)", act_ws, 0);
    check(bad_sd == 0, req, $sformatf("data mismatches=%0d first bit %0d value", bad_sd, first_k), act_sd, int'(!act_sd));
    check(bad_per == 0, "R2", "bit periods of wrong length", bad_per, 0);
    check((int'(rd) - base + 256) % 256 == nw, (under != 0) ? "R10" : "R4", "FIFO pops", (int'(rd) - base + 256) % 256, nw);
    check(!busy && !bclk_o && !sdo_o && (ws_o == wsp), "R9", "parked pins {busy,bclk,sdo,ws}",
          {busy, bclk_o, sdo_o, ws_o}, {3'b000, wsp});
    cap_on = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b0; fmt_sel = 2'd0; slot_ext = 5'd2; bclk_half = 8'd1;
    ws_left_high = 1'b0; bclk_invert = 1'b0; chan_mode = 2'd0; cap_on = 1'b0; wr = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // R5: I2S framing, 18-clock slots
    run_case("R5", 0, 2, 1, 1'b0, 1'b0, 0, 0, 3, 0);
    // R4: left-justified, shortest divider, inverted clock, left-high word select
    run_case("R4", 1, 0, 0, 1'b1, 1'b1, 0, 0, 2, 0);
    // R5: right-justified with padding
    run_case("R5", 2, 8, 2, 1'b0, 1'b0, 0, 0, 2, 0);
    // R5: I2S with 16-clock slots drops the LSB
    run_case("R5", 0, 0, 1, 1'b0, 1'b0, 0, 0, 2, 0);
    // R6: mute keeps clocks and pops
    run_case("R6", 0, 2, 1, 1'b0, 1'b0, 1, 1, 3, 0);
    // R7: mono-left and mono-right
    run_case("R7", 1, 4, 1, 1'b0, 1'b0, 2, 2, 2, 0);
    run_case("R7", 2, 3, 0, 1'b1, 1'b0, 3, 3, 2, 0);
    // R8: mode changes mid-pair take effect on the next pair
    run_case("R8", 1, 2, 1, 1'b0, 1'b0, 0, 1, 3, 0);
    run_case("R8", 0, 1, 0, 1'b0, 1'b1, 1, 0, 3, 0);
    // R10: underrun sends a zero pair
    run_case("R10", 0, 2, 1, 1'b0, 1'b0, 0, 0, 1, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule